// File: doc/BRIEF.md
# Link Cell Framer

This block produces the outgoing cell stream of a point-to-point serial link. One cell follows another with no gap. Each cell is 304 sixteen-bit words long: a 16-word header, a 160-word user payload and a 128-word parity region. The parity region stays at zero here, because a later error-correction encoder overwrites it. Line coding, serialisation and the encoder are outside this block.

Three payload sources compete for each cell: pattern, real-time and non-real-time. Each source presents one message at a time as a pending flag, a destination buffer number and a length in words. The framer fetches the message words on demand by placing an address on `rd_addr`. A message longer than one payload is split across several cells. The header of each cell carries:

- the segmentation flags;
- a running chunk offset;
- an optional remote initialisation write;
- four local flow-control bitmaps, piggybacked on every cell.

When no source is eligible, a no-op cell is sent, so the link always carries traffic.

Top module: `cell_framer`

## Requirements
- R1: After reset the block emits one word per cycle without a break. `out_sof` marks word 0 of every cell, and successive `out_sof` pulses are exactly 304 cycles apart.
- R2: Header word 0 is the command word, laid out as follows:
  - bits 3:0 hold the destination buffer;
  - bit 4 is the first-cell flag;
  - bit 5 is the last-cell flag;
  - bits 7:6 hold the cell type (0 pattern, 1 real-time, 2 non-real-time, 3 no-op);
  - bit 8 is the remote-init write enable;
  - bits 15:9 are zero.
- R3: Header word 1 is the cumulative message length through the end of this cell, in 32-word chunks, rounded up.
- R4: When `rinit_req` is high at a cell start, that cell sets the write enable and carries `rinit_data` in header word 2 (bits 31:16) and word 3 (bits 15:0), and `rinit_sent` pulses for one cycle. Otherwise words 2 and 3 are zero.
- R5: Header words 4 to 7 carry, in this order, the local non-real-time available, real-time available, non-real-time filled and real-time filled bitmaps, sampled at the cell start. Words 8 to 15 are zero.
- R6: Payload word i (words 16 to 175) is the source word at message address base+i, where base is the number of words already sent. Words past the end of the message are zero.
- R7: Words 176 to 303 are zero.
- R8: When several classes are eligible, the cell goes to pattern first, then real-time, then non-real-time.
- R9: The first cell of a real-time or non-real-time message is sent only if the far end's availability bit for its destination is set; continuation cells ignore that bit. Pattern messages are never gated.
- R10: A cell with no eligible class is a no-op cell with type 3, destination 0, both flags 0, offset 0 and a zero payload.
- R11: The first-cell flag marks a message's first cell and the last-cell flag marks the cell that carries its final word. A one-cycle `msg_done` pulse for that class follows during that cell.
- R12: While reset is held, `out_valid` and `out_sof` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_pend | input | 1 | Pattern message pending |
| pat_dest | input | 4 | Pattern destination buffer |
| pat_len | input | 16 | Pattern message length in words |
| pat_data | input | 16 | Pattern word at `rd_addr` |
| rt_pend | input | 1 | Real-time message pending |
| rt_dest | input | 4 | Real-time destination buffer |
| rt_len | input | 16 | Real-time message length in words |
| rt_data | input | 16 | Real-time word at `rd_addr` |
| nrt_pend | input | 1 | Non-real-time message pending |
| nrt_dest | input | 4 | Non-real-time destination buffer |
| nrt_len | input | 16 | Non-real-time message length in words |
| nrt_data | input | 16 | Non-real-time word at `rd_addr` |
| far_rt_avail | input | 16 | Far-end real-time buffers free |
| far_nrt_avail | input | 16 | Far-end non-real-time buffers free |
| loc_nrt_avail | input | 16 | Local non-real-time buffers free |
| loc_rt_avail | input | 16 | Local real-time buffers free |
| loc_nrt_filled | input | 16 | Local non-real-time buffers filled |
| loc_rt_filled | input | 16 | Local real-time buffers filled |
| rinit_req | input | 1 | Request to send a remote-init write |
| rinit_data | input | 32 | Remote-init write value |
| rinit_sent | output | 1 | Remote-init request taken into a cell |
| rd_addr | output | 16 | Message word address for the active class |
| msg_done | output | 3 | Per-class message complete pulse (bit 0 pattern, 1 real-time, 2 non-real-time) |
| out_valid | output | 1 | Output word valid |
| out_sof | output | 1 | Output word is word 0 of a cell |
| out_data | output | 16 | Output word |

## Verification
The hardest case to reach from the ports is a real-time message whose far-end availability is withdrawn after its first cell, while a pattern message cuts in before the final segment. The continuation must still be sent, and its offset and payload base must resume where they stopped. The stimulus reaches this state in stages. It first holds a real-time message back with its availability bit clear. It then grants the bit for exactly one cell and clears it again. Next it raises a short pattern message between two real-time cells. Finally it lets the 400-word message finish with a partly filled payload.

// File: rtl/cfr_pkg.sv
// Shared encodings for the link cell framer.
// Assumes a 16-bit header word; the command field occupies its low 9 bits.
package cfr_pkg;
    typedef enum logic [1:0] {
        CT_PAT = 2'd0,
        CT_RT  = 2'd1,
        CT_NRT = 2'd2,
        CT_NOP = 2'd3
    } cell_type_e;

    // Packed LSB-last: dest lands in bits 3:0, we in bit 8.
    typedef struct packed {
        logic       we;
        cell_type_e ctype;
        logic       last;
        logic       first;
        logic [3:0] dest;
    } cmd_t;
endpackage

// File: rtl/cfr_arbiter.sv
// Chooses the class that owns the next cell.
// Pattern is never gated. The real-time and non-real-time classes need the
// far-end availability bit of their destination unless a message is already
// in progress. Fixed priority: pattern, then real-time, then non-real-time.
module cfr_arbiter #(
    parameter int NBUF   = 16,
    parameter int DEST_W = 4
) (
    input  logic [2:0]        pend,
    input  logic [2:0]        inprog,
    input  logic [DEST_W-1:0] dest [3],
    input  logic [NBUF-1:0]   far_rt_avail,
    input  logic [NBUF-1:0]   far_nrt_avail,
    output logic [2:0]        grant,
    output logic [1:0]        sel,
    output cfr_pkg::cell_type_e ctype
);
    logic [2:0] elig;

    genvar c;
    generate
        for (c = 0; c < 3; c++) begin : g_elig
            if (c == 0) begin : g_free
                // Purpose: pattern traffic needs no credit.
                always_comb elig[c] = pend[c];
            end else begin : g_gated
                logic [NBUF-1:0] avail;
                assign avail = (c == 1) ? far_rt_avail : far_nrt_avail;
                // Purpose: credit is checked only before a message starts.
                always_comb elig[c] = pend[c] && (inprog[c] || avail[dest[c]]);
            end
        end
    endgenerate

    // Purpose: fixed-priority pick among the eligible classes.
    always_comb begin
        grant = 3'b000;
        sel   = 2'd0;
        ctype = cfr_pkg::CT_NOP;
        if (elig[0]) begin
            grant = 3'b001; sel = 2'd0; ctype = cfr_pkg::CT_PAT;
        end else if (elig[1]) begin
            grant = 3'b010; sel = 2'd1; ctype = cfr_pkg::CT_RT;
        end else if (elig[2]) begin
            grant = 3'b100; sel = 2'd2; ctype = cfr_pkg::CT_NRT;
        end
    end
endmodule

// File: rtl/cfr_seg.sv
// Per-class segmentation state. It holds the number of words already sent
// for each class and derives base, word count, flags and chunk offset for
// the granted class. It also raises a completion pulse at the end of the
// payload of a message's final cell.
// Assumes a source keeps its length stable until its message completes.
module cfr_seg #(
    parameter int LEN_W   = 16,
    parameter int PAY_W   = 160,
    parameter int CHUNK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fin_stb,
    input  logic [2:0]       grant,
    input  logic [1:0]       sel,
    input  logic [LEN_W-1:0] len [3],
    output logic [2:0]       inprog,
    output logic [LEN_W-1:0] base,
    output logic [LEN_W-1:0] cnt,
    output logic             first,
    output logic             last,
    output logic [LEN_W-1:0] off,
    output logic [2:0]       msg_done
);
    localparam int SH = $clog2(CHUNK_W);

    logic [LEN_W-1:0] prog [3];
    logic [2:0]       fin_pend;
    logic [LEN_W-1:0] rem;
    logic [LEN_W:0]   sum;
    logic [LEN_W:0]   rnd;

    // Purpose: segment arithmetic for the class about to be sent.
    always_comb begin
        base  = (|grant) ? prog[sel] : '0;
        rem   = (|grant) ? (len[sel] - base) : '0;
        last  = (rem <= LEN_W'(PAY_W));
        cnt   = last ? rem : LEN_W'(PAY_W);
        first = (base == '0);
        sum   = {1'b0, base} + {1'b0, cnt};
        rnd   = (sum + (LEN_W+1)'(CHUNK_W - 1)) >> SH;
        off   = rnd[LEN_W-1:0];
    end

    genvar c;
    generate
        for (c = 0; c < 3; c++) begin : g_cls
            assign inprog[c] = (prog[c] != '0);

            // Purpose: advance or clear the sent-word count at each cell start.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prog[c]     <= '0;
                    fin_pend[c] <= 1'b0;
                    msg_done[c] <= 1'b0;
                end else begin
                    if (start && grant[c]) begin
                        prog[c] <= last ? '0 : (base + LEN_W'(PAY_W));
                        if (last) fin_pend[c] <= 1'b1;
                    end
                    if (fin_stb) begin
                        msg_done[c] <= fin_pend[c];
                        fin_pend[c] <= 1'b0;
                    end else begin
                        msg_done[c] <= 1'b0;
                    end
                end
            end

            AST_DONE_CLEARS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
                msg_done[c] |-> (prog[c] == '0));                                   // R11
        end
    endgenerate

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(msg_done));                                                        // R11
endmodule

// File: rtl/cfr_words.sv
// Word selector for one cell position. It returns the header field, the
// payload word (zero past the end of the message) or a zero parity
// placeholder, and forms the message address sent to the sources.
// Assumes HDR_W >= 8 and 16-bit words.
module cfr_words #(
    parameter int HDR_W = 16,
    parameter int PAY_W = 160,
    parameter int CNT_W = 9,
    parameter int LEN_W = 16
) (
    input  logic [CNT_W-1:0] wcnt,
    input  cfr_pkg::cmd_t    cmd,
    input  logic [LEN_W-1:0] off,
    input  logic [31:0]      rinit,
    input  logic [15:0]      bm [4],
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] base,
    input  logic [15:0]      din,
    output logic [15:0]      word,
    output logic [LEN_W-1:0] rd_addr
);
    localparam int PAY_END = HDR_W + PAY_W;

    logic             in_hdr;
    logic             in_pay;
    logic [LEN_W-1:0] pidx;

    // Purpose: region decode and payload index.
    always_comb begin
        in_hdr  = (wcnt < CNT_W'(HDR_W));
        in_pay  = !in_hdr && (wcnt < CNT_W'(PAY_END));
        pidx    = LEN_W'(wcnt) - LEN_W'(HDR_W);
        rd_addr = base + (in_pay ? pidx : '0);
    end

    // Purpose: pick the word for this position.
    always_comb begin
        word = '0;
        if (in_pay) begin
            word = (pidx < cnt) ? din : 16'h0000;
        end else if (in_hdr) begin
            case (wcnt)
                CNT_W'(0): word = {7'd0, cmd};
                CNT_W'(1): word = off[15:0];
                CNT_W'(2): word = rinit[31:16];
                CNT_W'(3): word = rinit[15:0];
                CNT_W'(4), CNT_W'(5), CNT_W'(6), CNT_W'(7): word = bm[wcnt[1:0]];
                default:   word = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/cell_framer.sv
// Link cell framer top. A free-running word counter walks each cell. At the
// last word of a cell, the next cell's class, segment data, remote-init
// request and local bitmaps are latched, so every cell is self-consistent.
// The output word is registered.
// Assumes sources answer rd_addr combinationally within the cycle.
module cell_framer #(
    parameter int HDR_W   = 16,
    parameter int PAY_W   = 160,
    parameter int PAR_W   = 128,
    parameter int CHUNK_W = 32,
    parameter int NBUF    = 16,
    parameter int LEN_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_pend,
    input  logic [3:0]        pat_dest,
    input  logic [LEN_W-1:0]  pat_len,
    input  logic [15:0]       pat_data,
    input  logic              rt_pend,
    input  logic [3:0]        rt_dest,
    input  logic [LEN_W-1:0]  rt_len,
    input  logic [15:0]       rt_data,
    input  logic              nrt_pend,
    input  logic [3:0]        nrt_dest,
    input  logic [LEN_W-1:0]  nrt_len,
    input  logic [15:0]       nrt_data,
    input  logic [NBUF-1:0]   far_rt_avail,
    input  logic [NBUF-1:0]   far_nrt_avail,
    input  logic [15:0]       loc_nrt_avail,
    input  logic [15:0]       loc_rt_avail,
    input  logic [15:0]       loc_nrt_filled,
    input  logic [15:0]       loc_rt_filled,
    input  logic              rinit_req,
    input  logic [31:0]       rinit_data,
    output logic              rinit_sent,
    output logic [LEN_W-1:0]  rd_addr,
    output logic [2:0]        msg_done,
    output logic              out_valid,
    output logic              out_sof,
    output logic [15:0]       out_data
);
    import cfr_pkg::*;

    localparam int CELL_W = HDR_W + PAY_W + PAR_W;
    localparam int CNT_W  = $clog2(CELL_W);
    localparam int DEST_W = $clog2(NBUF);

    logic [CNT_W-1:0]  wcnt;
    logic              started;
    logic              start;
    logic              fin_stb;
    logic [DEST_W-1:0] dsts [3];
    logic [LEN_W-1:0]  lens [3];
    logic [2:0]        pend;
    logic [2:0]        inprog;
    logic [2:0]        grant;
    logic [1:0]        sel;
    cell_type_e        nxt_type;
    logic [LEN_W-1:0]  s_base, s_cnt, s_off;
    logic              s_first, s_last;

    cmd_t              cur_cmd;
    logic [LEN_W-1:0]  cur_off, cur_cnt, cur_base;
    logic [31:0]       cur_rinit;
    logic [15:0]       cur_bm [4];
    logic [15:0]       din;
    logic [15:0]       word;

    assign dsts[0] = pat_dest;
    assign dsts[1] = rt_dest;
    assign dsts[2] = nrt_dest;
    assign lens[0] = pat_len;
    assign lens[1] = rt_len;
    assign lens[2] = nrt_len;
    assign pend    = {nrt_pend, rt_pend, pat_pend};
    assign start   = (wcnt == CNT_W'(CELL_W - 1));
    assign fin_stb = (wcnt == CNT_W'(HDR_W + PAY_W - 1));

    cfr_arbiter #(.NBUF(NBUF), .DEST_W(DEST_W)) u_arb (
        .pend(pend), .inprog(inprog), .dest(dsts),
        .far_rt_avail(far_rt_avail), .far_nrt_avail(far_nrt_avail),
        .grant(grant), .sel(sel), .ctype(nxt_type)
    );

    cfr_seg #(.LEN_W(LEN_W), .PAY_W(PAY_W), .CHUNK_W(CHUNK_W)) u_seg (
        .clk(clk), .rst_n(rst_n), .start(start), .fin_stb(fin_stb),
        .grant(grant), .sel(sel), .len(lens), .inprog(inprog),
        .base(s_base), .cnt(s_cnt), .first(s_first), .last(s_last),
        .off(s_off), .msg_done(msg_done)
    );

    // Purpose: route the active class's data input to the word selector.
    always_comb begin
        case (cur_cmd.ctype)
            CT_PAT:  din = pat_data;
            CT_RT:   din = rt_data;
            CT_NRT:  din = nrt_data;
            default: din = 16'h0000;
        endcase
    end

    cfr_words #(.HDR_W(HDR_W), .PAY_W(PAY_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_words (
        .wcnt(wcnt), .cmd(cur_cmd), .off(cur_off), .rinit(cur_rinit),
        .bm(cur_bm), .cnt(cur_cnt), .base(cur_base), .din(din),
        .word(word), .rd_addr(rd_addr)
    );

    // Purpose: word counter and per-cell state capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt       <= CNT_W'(CELL_W - 1);
            started    <= 1'b0;
            cur_cmd    <= '0;
            cur_off    <= '0;
            cur_cnt    <= '0;
            cur_base   <= '0;
            cur_rinit  <= '0;
            rinit_sent <= 1'b0;
            for (int i = 0; i < 4; i++) cur_bm[i] <= '0;
        end else begin
            rinit_sent <= start && rinit_req;
            if (start) begin
                wcnt          <= '0;
                started       <= 1'b1;
                cur_cmd.we    <= rinit_req;
                cur_cmd.ctype <= nxt_type;
                cur_cmd.dest  <= (|grant) ? dsts[sel] : '0;
                cur_cmd.first <= (|grant) && s_first;
                cur_cmd.last  <= (|grant) && s_last;
                cur_off       <= (|grant) ? s_off : '0;
                cur_cnt       <= s_cnt;
                cur_base      <= s_base;
                cur_rinit     <= rinit_req ? rinit_data : 32'h0;
                cur_bm[0]     <= loc_nrt_avail;
                cur_bm[1]     <= loc_rt_avail;
                cur_bm[2]     <= loc_nrt_filled;
                cur_bm[3]     <= loc_rt_filled;
            end else begin
                wcnt <= wcnt + CNT_W'(1);
            end
        end
    end

    // Purpose: register the outgoing word and its framing flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= started;
            out_sof   <= started && (wcnt == '0);
            out_data  <= word;
        end
    end

    AST_SOF_ON_FIRST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sof);                                              // R1
    AST_VALID_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_valid) |-> out_valid);                                            // R1
    AST_CMD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_data[15:9] == 7'd0));                                      // R2
    AST_RINIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rinit_sent |=> !rinit_sent);                                                // R4
endmodule

// File: tb/sim_cell_framer.sv
// Scoreboard bench: run_cell predicts each cell from the requirements and
// queues its words; a monitor compares the stream word by word.
module sim_cell_framer;
    localparam int CELL = 304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_pend = 0, rt_pend = 0, nrt_pend = 0;
    logic [3:0]  pat_dest = 0, rt_dest = 0, nrt_dest = 0;
    logic [15:0] pat_len = 0, rt_len = 0, nrt_len = 0;
    logic [15:0] pat_data, rt_data, nrt_data;
    logic [15:0] far_rt_avail = 0, far_nrt_avail = 0;
    logic [15:0] loc_nrt_avail = 0, loc_rt_avail = 0, loc_nrt_filled = 0, loc_rt_filled = 0;
    logic        rinit_req = 0;
    logic [31:0] rinit_data = 0;
    logic        rinit_sent;
    logic [15:0] rd_addr;
    logic [2:0]  msg_done;
    logic        out_valid, out_sof;
    logic [15:0] out_data;

    int errors = 0;
    int checks = 0;
    int b_prog [3] = '{0, 0, 0};
    int done_cnt [3] = '{0, 0, 0};
    int rs_cnt = 0;
    logic [15:0] exp_q [$];
    string       scen_q [$];

    always #10 clk = ~clk;

    // Source memories as functions of address, one offset per class.
    assign pat_data = 16'hA000 + rd_addr;
    assign rt_data  = 16'h5000 + rd_addr;
    assign nrt_data = 16'hC000 + rd_addr;

    cell_framer u0 (
        .clk(clk), .rst_n(rst_n),
        .pat_pend(pat_pend), .pat_dest(pat_dest), .pat_len(pat_len), .pat_data(pat_data),
        .rt_pend(rt_pend), .rt_dest(rt_dest), .rt_len(rt_len), .rt_data(rt_data),
        .nrt_pend(nrt_pend), .nrt_dest(nrt_dest), .nrt_len(nrt_len), .nrt_data(nrt_data),
        .far_rt_avail(far_rt_avail), .far_nrt_avail(far_nrt_avail),
        .loc_nrt_avail(loc_nrt_avail), .loc_rt_avail(loc_rt_avail),
        .loc_nrt_filled(loc_nrt_filled), .loc_rt_filled(loc_rt_filled),
        .rinit_req(rinit_req), .rinit_data(rinit_data), .rinit_sent(rinit_sent),
        .rd_addr(rd_addr), .msg_done(msg_done),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    function automatic string region(input int i);
        if (i == 0)   return "R2 command";
        if (i == 1)   return "R3 offset";
        if (i < 4)    return "R4 remote init";
        if (i < 16)   return "R5 bitmaps";
        if (i < 176)  return "R6 payload";
        return "R7 parity";
    endfunction

    // Predict the next cell from the current inputs and queue it.
    task automatic run_cell(input string scen);
        logic [15:0] w [CELL];
        bit [2:0] el;
        int cls, len, base, rem, cnt, off, dest, dbase;
        bit fin, first;
        for (int i = 0; i < CELL; i++) w[i] = 16'h0;
        el[0] = pat_pend;
        el[1] = rt_pend && (b_prog[1] != 0 || far_rt_avail[rt_dest]);
        el[2] = nrt_pend && (b_prog[2] != 0 || far_nrt_avail[nrt_dest]);
        cls = el[0] ? 0 : el[1] ? 1 : el[2] ? 2 : 3;
        fin = 0; first = 0; off = 0; dest = 0;
        if (cls < 3) begin
            len   = (cls == 0) ? int'(pat_len) : (cls == 1) ? int'(rt_len) : int'(nrt_len);
            dest  = (cls == 0) ? int'(pat_dest) : (cls == 1) ? int'(rt_dest) : int'(nrt_dest);
            dbase = (cls == 0) ? 'hA000 : (cls == 1) ? 'h5000 : 'hC000;
            base  = b_prog[cls];
            rem   = len - base;
            fin   = (rem <= 160);
            cnt   = fin ? rem : 160;
            first = (base == 0);
            off   = (base + cnt + 31) / 32;
            for (int i = 0; i < cnt; i++) w[16+i] = 16'(dbase + base + i);
            b_prog[cls] = fin ? 0 : base + 160;
        end
        w[0] = 16'(dest + (int'(first) << 4) + (int'(fin) << 5) + (cls << 6)
                    + (int'(rinit_req) << 8));
        w[1] = 16'(off);
        if (rinit_req) begin
            w[2] = rinit_data[31:16];
            w[3] = rinit_data[15:0];
        end
        w[4] = loc_nrt_avail;  w[5] = loc_rt_avail;
        w[6] = loc_nrt_filled; w[7] = loc_rt_filled;
        for (int i = 0; i < CELL; i++) exp_q.push_back(w[i]);
        scen_q.push_back(scen);
        do @(negedge clk); while (!out_sof);
        if (fin && cls == 0) pat_pend = 0;
        if (fin && cls == 1) rt_pend = 0;
        if (fin && cls == 2) nrt_pend = 0;
        rinit_req = 0;
    endtask

    // Monitor: pop and compare one word per valid output cycle.
    int    k = -1;
    int    since = 0;
    bit    have_prev = 0;
    bit    bad = 0;
    string cur_scen = "";
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            since++;
            if (out_sof) begin
                if (have_prev)
                    check(since == CELL, "R1 cell spacing", since, CELL);
                have_prev = 1;
                since = 0;
                if (k >= 0)
                    check(0, "R1 early start of cell", k, CELL);
                if (exp_q.size() >= CELL) begin
                    k = 0; bad = 0; cur_scen = scen_q.pop_front();
                end else begin
                    k = -1;
                end
            end
            if (k >= 0) begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (out_data !== e && !bad) begin
                    bad = 1;
                    $display("FAIL %s [%s] word %0d: actual %h expected %h",
                             region(k), cur_scen, k, out_data, e);
                end
                k++;
                if (k == CELL) begin
                    checks++;
                    if (bad) errors++;
                    k = -1;
                end
            end
        end
    end

    // Pulse counters for R11 and R4.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 3; c++) if (msg_done[c]) done_cnt[c]++;
            if (rinit_sent) rs_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        loc_nrt_avail = 16'h00F1; loc_rt_avail = 16'h1234;
        loc_nrt_filled = 16'h0A0A; loc_rt_filled = 16'h5005;
        far_nrt_avail = 16'h0008;
        repeat (4) @(negedge clk);
        check(out_valid === 1'b0 && out_sof === 1'b0, "R12 outputs idle in reset",
              int'({out_valid, out_sof}), 0);
        rst_n = 1'b1;

        run_cell("R10 idle no-op");
        rinit_req = 1; rinit_data = 32'hCAFE_0123; loc_rt_avail = 16'h4321;
        run_cell("R4 remote init on no-op");
        nrt_pend = 1; nrt_dest = 4'd3; nrt_len = 16'd50;
        run_cell("R6 short padded non-real-time");
        rt_pend = 1; rt_dest = 4'd5; rt_len = 16'd400;
        run_cell("R9 real-time held without credit");
        far_rt_avail = 16'h0020;
        run_cell("R9 real-time first cell with credit");
        far_rt_avail = 16'h0000;
        run_cell("R9 continuation ignores credit");
        pat_pend = 1; pat_dest = 4'd2; pat_len = 16'd20;
        run_cell("R8 pattern preempts real-time");
        run_cell("R11 real-time final segment");
        rt_pend = 1; rt_dest = 4'd7; rt_len = 16'd10; far_rt_avail = 16'h0080;
        nrt_pend = 1; nrt_dest = 4'd3; nrt_len = 16'd160;
        run_cell("R8 real-time before non-real-time");
        run_cell("R3 exact full payload");
        run_cell("R10 back to no-op");
        repeat (CELL + 8) @(negedge clk);

        check(done_cnt[0] == 1, "R11 pattern completions", done_cnt[0], 1);
        check(done_cnt[1] == 2, "R11 real-time completions", done_cnt[1], 2);
        check(done_cnt[2] == 2, "R11 non-real-time completions", done_cnt[2], 2);
        check(rs_cnt == 1, "R4 remote init taken once", rs_cnt, 1);
        check(exp_q.size() == 0, "R1 all predicted words seen", exp_q.size(), 0);
        summary();
    end
endmodule